// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Level and Idle Timeout

This block buffers received characters for a UART between the line receiver and the host. Bytes arrive from the receiver (or from the loopback path) through a one-cycle write strobe. The host removes them one at a time through a read strobe and gets the byte on the following cycle. The block keeps live empty, full and trigger-level flags. It also produces two single-cycle events for the interrupt logic: one when a byte is lost to a full buffer, and one when the line has gone quiet for four character times since the last stored byte.

The character time comes from the serial frame settings that the block receives on its ports: clocks per bit, data length, parity on or off, and one or two stop bits. The receive path is gated by a single enable input that the control logic supplies. While that input is low, the buffer neither accepts bytes nor gives them up. A synchronous receive-reset strobe discards the contents without touching the programmed trigger level.

Top module: `uart_rx_fifo`

## Requirements
- R1: The buffer holds up to 16 bytes and returns them in arrival order. `level` reports the number of bytes stored, and the read slot is the write slot minus `level`, modulo 16.
- R2: A write while `level` is 16 discards the byte, leaves the contents unchanged and pulses `ovr_evt` high for one cycle on the following cycle.
- R3: `trig_hit` sets after an accepted write that leaves `level` greater than or equal to `trig_lvl`. It clears after an enabled read that leaves `level` below `trig_lvl`. Otherwise it holds its value.
- R4: A read while empty returns 0 on `rd_data` and keeps `empty` high. A read that removes the last byte sets `empty`. `rd_data` is valid in the cycle after `rd_req`.
- R5: `full` goes high when a write brings `level` to 16. Any enabled read clears it.
- R6: Each accepted write reloads the idle timer with 4 × `bit_clks` × F clocks, where F = 1 + D + P + S. D is 6 for `dsel`=0, 7 for `dsel`=1 and 8 otherwise. P is `par_en`. S is 2 when `two_stop`=1 and 1 otherwise. `tmo_evt` is high for exactly one cycle, that many clock edges after the write's edge, provided no further write occurs in between.
- R7: `rx_rst` empties the buffer, sets `empty`, clears `full` and `trig_hit`, and stops the idle timer.
- R8: While `rx_on` is 0, writes and reads leave `level` and the contents unchanged, and a read returns 0.
- R9: A write with `wr_brk` high stores the byte 0x00, whatever `wr_data` holds.
- R10: A read and a write in the same cycle are judged against the level at the start of that cycle. When the buffer is neither empty nor full, `level` stays unchanged. When it is empty, the read returns 0 and the byte is stored. When it is full, the byte is lost with `ovr_evt` and one byte is read.
- R11: After `rst_n` the buffer is empty, with `empty`=1, `full`=0, `trig_hit`=0, `rd_data`=0, and `trig_lvl`=0x20.
- R12: A cycle with `trig_we` high loads `trig_wdata` into `trig_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_rst | input | 1 | Receive reset strobe |
| rx_on | input | 1 | Receive path effectively enabled |
| trig_we | input | 1 | Load strobe for the trigger level |
| trig_wdata | input | 6 | New trigger level |
| trig_lvl | output | 6 | Current trigger level |
| bit_clks | input | 12 | Clocks per serial bit |
| dsel | input | 2 | Data length select |
| par_en | input | 1 | Parity bit present in frame |
| two_stop | input | 1 | Two stop bits |
| wr_valid | input | 1 | Received byte strobe |
| wr_brk | input | 1 | Strobe carries a break (stored as zero) |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Host read strobe |
| rd_data | output | 8 | Byte read, valid the cycle after rd_req |
| level | output | 5 | Bytes stored |
| empty | output | 1 | Buffer empty flag |
| full | output | 1 | Buffer full flag |
| trig_hit | output | 1 | Trigger level reached flag |
| ovr_evt | output | 1 | Overrun event pulse |
| tmo_evt | output | 1 | Idle timeout event pulse |

## Verification
The hardest situation to reach is the trigger flag at its extreme settings. A level of 0 keeps the flag set even after the buffer drains, a level of 16 sets it only on the write that fills the buffer, and levels above 16 never set it. The stimulus therefore sweeps every trigger level from 0 to 17. For each level it fills the buffer to overflow, drains it past empty, and computes the expected flag after every step. The idle timeout is measured edge by edge for all frame-format combinations at a small bit period. A second write part-way through one interval shows that the timer restarts from the newest byte.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DW       = 8,
  parameter int DEPTH    = 16,
  parameter int TRIG_W   = 6,
  parameter int TRIG_RST = 32,
  parameter int BP_W     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_rst,
  input  logic                     rx_on,
  input  logic                     trig_we,
  input  logic [TRIG_W-1:0]        trig_wdata,
  output logic [TRIG_W-1:0]        trig_lvl,
  input  logic [BP_W-1:0]          bit_clks,
  input  logic [1:0]               dsel,
  input  logic                     par_en,
  input  logic                     two_stop,
  input  logic                     wr_valid,
  input  logic                     wr_brk,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_req,
  output logic [DW-1:0]            rd_data,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     empty,
  output logic                     full,
  output logic                     trig_hit,
  output logic                     ovr_evt,
  output logic                     tmo_evt
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = BP_W + 6;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp;
  logic [TW-1:0] tmr;
  logic          armed;

  wire is_full   = (level == CW'(DEPTH));
  wire is_empty  = (level == '0);
  wire push_req  = rx_on & wr_valid;
  wire pop_req   = rx_on & rd_req;
  wire push      = push_req & ~is_full;
  wire pop       = pop_req & ~is_empty;
  wire [AW-1:0] rp  = wp - level[AW-1:0];
  wire [CW-1:0] nxt = level + CW'(push) - CW'(pop);
  wire [DW-1:0] din = wr_brk ? '0 : wr_data;
  wire reach = 32'(nxt) >= 32'(trig_lvl);

  wire [3:0] dbits = (dsel == 2'd0) ? 4'd6 : (dsel == 2'd1) ? 4'd7 : 4'd8;
  wire [3:0] flen  = 4'd1 + dbits + {3'd0, par_en} + (two_stop ? 4'd2 : 4'd1);
  wire [TW-1:0] tmo_load = (TW'(bit_clks) * TW'(flen)) << 2;

  always_ff @(posedge clk)
    if (push && !rx_rst) mem[wp] <= din;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_lvl <= TRIG_W'(TRIG_RST);
    else if (trig_we) trig_lvl <= trig_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_req) rd_data <= pop ? mem[rp] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_rst) begin
      wp       <= '0;
      level    <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      trig_hit <= 1'b0;
      ovr_evt  <= 1'b0;
    end else begin
      ovr_evt <= push_req & is_full;
      level   <= nxt;
      if (push) wp <= wp + 1'b1;
      if (push || pop_req) empty <= (nxt == '0);
      if (push && nxt == CW'(DEPTH)) full <= 1'b1;
      else if (pop_req)              full <= 1'b0;
      if (push && reach)             trig_hit <= 1'b1;
      else if (pop_req && !reach)    trig_hit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_rst) begin
      tmr     <= '0;
      armed   <= 1'b0;
      tmo_evt <= 1'b0;
    end else begin
      tmo_evt <= 1'b0;
      if (push) begin
        tmr   <= tmo_load;
        armed <= (tmo_load != '0);
      end else if (armed) begin
        tmr <= tmr - 1'b1;
        if (tmr == TW'(1)) begin
          armed   <= 1'b0;
          tmo_evt <= 1'b1;
        end
      end
    end
  end

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R2
  overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && wr_valid && !rd_req && !rx_rst && level == CW'(DEPTH))
      |=> (ovr_evt && level == CW'(DEPTH)));

  // R4
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && rd_req && !wr_valid && !rx_rst && level == '0)
      |=> (rd_data == '0 && empty));

  // R5
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full == (level == CW'(DEPTH)));

  // R6
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !tmo_evt);

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && !rx_rst) |=> $stable(level));

  // R10
  rw_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && wr_valid && rd_req && !rx_rst && level != '0 && level != CW'(DEPTH))
      |=> $stable(level));

endmodule

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_rst = 1'b0, rx_on = 1'b0;
  logic       trig_we = 1'b0;
  logic [5:0] trig_wdata = '0, trig_lvl;
  logic [11:0] bit_clks = 12'd3;
  logic [1:0] dsel = 2'd2;
  logic       par_en = 1'b0, two_stop = 1'b0;
  logic       wr_valid = 1'b0, wr_brk = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic [4:0] level;
  logic       empty, full, trig_hit, ovr_evt, tmo_evt;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .rx_rst(rx_rst), .rx_on(rx_on),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .trig_lvl(trig_lvl),
    .bit_clks(bit_clks), .dsel(dsel), .par_en(par_en), .two_stop(two_stop),
    .wr_valid(wr_valid), .wr_brk(wr_brk), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .level(level),
    .empty(empty), .full(full), .trig_hit(trig_hit),
    .ovr_evt(ovr_evt), .tmo_evt(tmo_evt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic b, input logic [7:0] d, input logic r);
    wr_valid = w; wr_brk = b; wr_data = d; rd_req = r;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_brk = 1'b0; rd_req = 1'b0;
  endtask

  task automatic do_rxrst();
    rx_rst = 1'b1; @(posedge clk); #1; rx_rst = 1'b0;
  endtask

  task automatic set_trig(input int t);
    trig_we = 1'b1; trig_wdata = 6'(t); @(posedge clk); #1; trig_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    chk("R11 level", level, 0);
    chk("R11 empty", empty, 1);
    chk("R11 full", full, 0);
    chk("R11 trig_hit", trig_hit, 0);
    chk("R11 rd_data", rd_data, 0);
    chk("R11 trig_lvl", trig_lvl, 32);
    rx_on = 1'b1;

    // R1 R2 R3 R4 R5 R12: sweep every trigger level across fill and drain
    for (int t = 0; t <= 17; t++) begin
      set_trig(t);
      chk("R12 trig_lvl", trig_lvl, t);
      do_rxrst();
      chk("R7 trig_hit cleared", trig_hit, 0);
      for (int i = 0; i < 16; i++) begin
        step(1'b1, 1'b0, 8'((t * 16 + i) * 7), 1'b0);
        chk("R1 level fill", level, i + 1);
        chk("R3 trig on fill", trig_hit, (i + 1 >= t) ? 1 : 0);
        chk("R5 full on fill", full, (i == 15) ? 1 : 0);
        chk("R4 empty on fill", empty, 0);
      end
      step(1'b1, 1'b0, 8'hEE, 1'b0);
      chk("R2 overrun pulse", ovr_evt, 1);
      chk("R2 level kept", level, 16);
      step(1'b0, 1'b0, 8'h00, 1'b0);
      chk("R2 pulse ends", ovr_evt, 0);
      for (int j = 0; j < 16; j++) begin
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R1 order", rd_data, (((t * 16 + j) * 7) & 255));
        chk("R1 level drain", level, 15 - j);
        chk("R3 trig on drain", trig_hit, (t <= 16 && 15 - j >= t) ? 1 : 0);
        chk("R5 full cleared", full, 0);
        chk("R4 empty on drain", empty, (j == 15) ? 1 : 0);
      end
      step(1'b0, 1'b0, 8'h00, 1'b1);
      chk("R4 empty read zero", rd_data, 0);
      chk("R4 empty stays", empty, 1);
      chk("R3 trig after empty read", trig_hit, (t == 0) ? 1 : 0);
    end

    // R7 receive reset with data present
    set_trig(2);
    do_rxrst();
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 8'(i + 1), 1'b0);
    do_rxrst();
    chk("R7 level", level, 0);
    chk("R7 empty", empty, 1);
    chk("R7 full", full, 0);
    chk("R7 trig_hit", trig_hit, 0);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R7 read after reset", rd_data, 0);

    // R8 disabled path
    step(1'b1, 1'b0, 8'h11, 1'b0);
    step(1'b1, 1'b0, 8'h22, 1'b0);
    rx_on = 1'b0;
    step(1'b1, 1'b0, 8'h33, 1'b0);
    chk("R8 write ignored", level, 2);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R8 read returns zero", rd_data, 0);
    chk("R8 read ignored", level, 2);
    rx_on = 1'b1;
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R8 first byte kept", rd_data, 8'h11);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R8 second byte kept", rd_data, 8'h22);

    // R9 break stored as zero
    step(1'b1, 1'b1, 8'hAB, 1'b0);
    chk("R9 break stored", level, 1);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R9 break byte", rd_data, 0);
    chk("R9 empty after", empty, 1);

    // R10 simultaneous read and write
    step(1'b1, 1'b0, 8'h5A, 1'b1);
    chk("R10 empty rw data", rd_data, 0);
    chk("R10 empty rw level", level, 1);
    chk("R10 empty rw flag", empty, 0);
    step(1'b1, 1'b0, 8'h61, 1'b0);
    step(1'b1, 1'b0, 8'h62, 1'b1);
    chk("R10 mid rw data", rd_data, 8'h5A);
    chk("R10 mid rw level", level, 2);
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 8'(8'h70 + i), 1'b0);
    chk("R10 full reached", level, 16);
    step(1'b1, 1'b0, 8'hFF, 1'b1);
    chk("R10 full rw data", rd_data, 8'h61);
    chk("R10 full rw overrun", ovr_evt, 1);
    chk("R10 full rw level", level, 15);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R10 order kept", rd_data, 8'h62);

    // R6 idle timeout over every frame format
    bit_clks = 12'd3;
    for (int ds = 0; ds < 4; ds++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++) begin
          int exp_n, n, early;
          dsel = 2'(ds); par_en = p[0]; two_stop = s[0];
          do_rxrst();
          exp_n = 4 * 3 * (1 + ((ds == 0) ? 6 : (ds == 1) ? 7 : 8) + p + s + 1);
          step(1'b1, 1'b0, 8'h01, 1'b0);
          n = 0;
          early = 0;
          while (n < 1000) begin
            @(posedge clk); #1;
            n++;
            if (tmo_evt) break;
          end
          chk("R6 timeout cycles", n, exp_n);
          @(posedge clk); #1;
          chk("R6 single pulse", tmo_evt, 0);
        end

    // R6 restart on a second write
    do_rxrst();
    dsel = 2'd2; par_en = 1'b1; two_stop = 1'b1;
    begin
      int n, seen;
      seen = 0;
      step(1'b1, 1'b0, 8'h01, 1'b0);
      for (int i = 0; i < 50; i++) begin
        @(posedge clk); #1;
        if (tmo_evt) seen = 1;
      end
      step(1'b1, 1'b0, 8'h02, 1'b0);
      n = 0;
      while (n < 1000) begin
        @(posedge clk); #1;
        n++;
        if (tmo_evt) break;
      end
      chk("R6 no early timeout", seen, 0);
      chk("R6 restart cycles", n, 4 * 3 * 12);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule